// File: doc/BRIEF.md
# Chunked Ring Buffer Writer with Overflow Discard

This block takes a stream of 16-bit received samples and stores them in a circular buffer, one fixed-size chunk at a time. A consumer reads the stored samples through a synchronous read port. It reports how far it has read by writing a tail pointer into the block. The head pointer is the base address of the chunk being filled. Everything from the tail up to the head is complete and safe to read.

The block decides where the next chunk goes only when the last sample of the current chunk is accepted. At that point it works out the free space from the head and tail pointers. If there is room, it moves the head forward by one chunk and sends the following samples to the new head. If there is no room, the next whole chunk is sent to a discard target instead, and a sticky overflow flag is raised. The input never stalls, and unread data is never overwritten. Chunks sent to the discard target are also checked when they complete, so normal writing resumes one chunk boundary after the consumer frees space.

Top module: `ring_chunk_writer`

## Requirements
- R1: After a synchronous reset, the head is 0, `overflow_o` is 0, `dumping_o` is 0, and the first chunk is written starting at address 0.
- R2: Each cycle with `in_valid` high stores `in_data` at address head + k, where k is the sample's position (0 to CHUNK-1) within the current chunk. Cycles with `in_valid` low store nothing and do not advance k.
- R3: The write target is re-evaluated only in the cycle that accepts sample CHUNK-1 of a chunk. The head does not change in any other cycle.
- R4: At a check, the free space is computed from head h and tail t, with buffer size DEPTH:
  - if h == t, free = DEPTH - CHUNK;
  - if h > t, free = DEPTH - (h - t) - CHUNK;
  - otherwise, free = t - h - CHUNK.
  
  The buffer counts as full when free is 0 or less.
- R5: If free is positive at a check, the head becomes (head + CHUNK) mod DEPTH on the next cycle. A sample accepted in the very next cycle is written at the new head, with no idle cycle needed.
- R6: If the buffer is full at a check, the next chunk is discarded. `dumping_o` is 1 while that chunk is received, `overflow_o` becomes 1, the head stays unchanged, and no ring location is written.
- R7: A discarded chunk is also checked when it completes. If space is free by then, the head advances as in R5 and `dumping_o` returns to 0.
- R8: `overflow_o` stays set until `ovf_clr` is high in a cycle without a new overflow. When a new overflow and `ovf_clr` fall in the same cycle, the flag stays set.
- R9: A tail write (`tail_we` high, new value on `tail_wdata`) in the same cycle as a check takes effect at the next check, not the current one.
- R10: `rd_data` holds the ring contents at `rd_addr` one clock after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | SAMPLE_W | Received sample |
| tail_we | input | 1 | Consumer tail update strobe |
| tail_wdata | input | log2(DEPTH) | New tail address |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| rd_addr | input | log2(DEPTH) | Consumer read address |
| rd_data | output | SAMPLE_W | Ring data at `rd_addr`, one cycle later |
| head_o | output | log2(DEPTH) | Base address of the chunk being filled |
| dumping_o | output | 1 | Current chunk is being discarded |
| overflow_o | output | 1 | Sticky overflow flag |

## Verification
Two pairs of events can fall in the same cycle:
- **Tail write and free-space check.** The bench drives a tail write together with the final sample of a discarded chunk. It then expects the buffer to stay full, because the check must use the old tail. One chunk later it expects the head to wrap to zero.
- **Overflow clear and new overflow.** The bench asserts `ovf_clr` on the boundary sample of a chunk that finds the buffer full. It expects the overflow flag to remain set.

Read-back over the whole ring after discarded chunks confirms that discarded samples never reach consumer-visible storage.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic {TGT_RING = 1'b0, TGT_DUMP = 1'b1} tgt_e;
endpackage

// File: rtl/ring_space_calc.sv
module ring_space_calc #(
  parameter int DEPTH = 32,
  parameter int CHUNK = 4
) (
  input  logic [$clog2(DEPTH)-1:0] head_i,
  input  logic [$clog2(DEPTH)-1:0] tail_i,
  output logic                     room_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = AW + 2;
  localparam logic signed [SW-1:0] DEPTH_S = SW'(DEPTH);
  localparam logic signed [SW-1:0] CHUNK_S = SW'(CHUNK);

  logic signed [SW-1:0] h_s, t_s, free_s;

  always_comb begin
    h_s = $signed({2'b00, head_i});
    t_s = $signed({2'b00, tail_i});
    if (head_i == tail_i)
      free_s = DEPTH_S - CHUNK_S;
    else if (head_i > tail_i)
      free_s = DEPTH_S - (h_s - t_s) - CHUNK_S;
    else
      free_s = t_s - h_s - CHUNK_S;
    room_o = (free_s > 0);
  end
endmodule

// File: rtl/ring_chunk_seq.sv
module ring_chunk_seq #(
  parameter int DEPTH = 32,
  parameter int CHUNK = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid_i,
  input  logic                     tail_we_i,
  input  logic [$clog2(DEPTH)-1:0] tail_wdata_i,
  input  logic                     ovf_clr_i,
  output logic                     wr_en_o,
  output logic [$clog2(DEPTH)-1:0] wr_addr_o,
  output logic [$clog2(DEPTH)-1:0] head_o,
  output logic                     dumping_o,
  output logic                     overflow_o
);
  import ring_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = (CHUNK > 1) ? $clog2(CHUNK) : 1;
  localparam logic [AW-1:0] CHUNK_A = AW'(CHUNK);
  localparam logic [CW-1:0] LAST_K  = CW'(CHUNK - 1);

  logic [CW-1:0] off_q;
  logic [AW-1:0] head_q, tail_q;
  tgt_e          tgt_q;
  logic          ovf_q;
  logic          room;
  logic          boundary;

  ring_space_calc #(.DEPTH(DEPTH), .CHUNK(CHUNK)) u_space (
    .head_i (head_q),
    .tail_i (tail_q),
    .room_o (room)
  );

  assign boundary = in_valid_i && (off_q == LAST_K);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      tgt_q  <= TGT_RING;
      ovf_q  <= 1'b0;
    end else begin
      if (tail_we_i)
        tail_q <= tail_wdata_i;
      if (in_valid_i)
        off_q <= boundary ? '0 : off_q + CW'(1);
      if (boundary) begin
        if (room) begin
          head_q <= head_q + CHUNK_A;
          tgt_q  <= TGT_RING;
        end else begin
          tgt_q  <= TGT_DUMP;
        end
      end
      if (boundary && !room)
        ovf_q <= 1'b1;
      else if (ovf_clr_i)
        ovf_q <= 1'b0;
    end
  end

  assign wr_en_o    = in_valid_i && (tgt_q == TGT_RING);
  assign wr_addr_o  = head_q + AW'(off_q);
  assign head_o     = head_q;
  assign dumping_o  = (tgt_q == TGT_DUMP);
  assign overflow_o = ovf_q;

  // R3: head moves only at a chunk boundary
  p_head_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(head_q));

  // R5: room at a check advances the head one chunk and targets the ring
  p_advance_r5: assert property (@(posedge clk) disable iff (rst)
    (boundary && room) |=> (head_q == $past(head_q) + CHUNK_A) && (tgt_q == TGT_RING));

  // R6: a full check diverts to discard, flags overflow, keeps head
  p_dump_r6: assert property (@(posedge clk) disable iff (rst)
    (boundary && !room) |=> (tgt_q == TGT_DUMP) && ovf_q && $stable(head_q));

  // R8: overflow is sticky without a clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ovf_clr_i) |=> ovf_q);

  // R2: sample position holds when no sample arrives
  p_pos_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> $stable(off_q));
endmodule

// File: rtl/ring_store.sv
module ring_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [DW-1:0]            rdata_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i)
      mem[waddr_i] <= wdata_i;
    rd_q <= mem[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/ring_chunk_writer.sv
module ring_chunk_writer #(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 32,
  parameter int CHUNK    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [SAMPLE_W-1:0]      in_data,
  input  logic                     tail_we,
  input  logic [$clog2(DEPTH)-1:0] tail_wdata,
  input  logic                     ovf_clr,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [SAMPLE_W-1:0]      rd_data,
  output logic [$clog2(DEPTH)-1:0] head_o,
  output logic                     dumping_o,
  output logic                     overflow_o
);
  localparam int AW = $clog2(DEPTH);

  logic          ring_we;
  logic [AW-1:0] ring_waddr;

  ring_chunk_seq #(.DEPTH(DEPTH), .CHUNK(CHUNK)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .in_valid_i   (in_valid),
    .tail_we_i    (tail_we),
    .tail_wdata_i (tail_wdata),
    .ovf_clr_i    (ovf_clr),
    .wr_en_o      (ring_we),
    .wr_addr_o    (ring_waddr),
    .head_o       (head_o),
    .dumping_o    (dumping_o),
    .overflow_o   (overflow_o)
  );

  ring_store #(.DW(SAMPLE_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .we_i    (ring_we),
    .waddr_i (ring_waddr),
    .wdata_i (in_data),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  // R6: while discarding, nothing reaches the ring storage
  p_no_ring_write_r6: assert property (@(posedge clk) disable iff (rst)
    dumping_o |-> !ring_we);
endmodule

// File: tb/ring_chunk_writer_tb.sv
module ring_chunk_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int CHUNK = 4;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic tail_we = 1'b0;
  logic [AW-1:0] tail_wdata = '0;
  logic ovf_clr = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [AW-1:0] head_o;
  logic dumping_o, overflow_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_chunk_writer #(.SAMPLE_W(16), .DEPTH(DEPTH), .CHUNK(CHUNK)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .tail_we(tail_we), .tail_wdata(tail_wdata), .ovf_clr(ovf_clr),
    .rd_addr(rd_addr), .rd_data(rd_data), .head_o(head_o),
    .dumping_o(dumping_o), .overflow_o(overflow_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input int h, input bit d, input bit o);
    check(head_o == AW'(h), {tag, " head"}, int'(head_o), h);
    check(dumping_o == d, {tag, " dumping"}, int'(dumping_o), int'(d));
    check(overflow_o == o, {tag, " overflow"}, int'(overflow_o), int'(o));
  endtask

  // one sample; starts and ends at a falling edge
  task automatic push(input logic [15:0] d, input bit twe, input int tv, input bit clr);
    in_valid = 1'b1; in_data = d;
    tail_we = twe; tail_wdata = AW'(tv); ovf_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; tail_we = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic push_chunk(input int base_val);
    for (int i = 0; i < CHUNK; i++) push(16'(base_val + i), 1'b0, 0, 1'b0);
  endtask

  task automatic read_chk(input int a, input int exp, input string tag);
    rd_addr = AW'(a);
    @(negedge clk);
    check(rd_data == 16'(exp), tag, int'(rd_data), exp);
  endtask

  task automatic t_reset;
    chk_state("R1 reset", 0, 1'b0, 1'b0);
  endtask

  task automatic t_fill;
    push_chunk(16'h2000);
    chk_state("R1 R5 first chunk", 4, 1'b0, 1'b0);
    push(16'h2004, 1'b0, 0, 1'b0);
    repeat (3) @(negedge clk);
    push(16'h2005, 1'b0, 0, 1'b0);
    repeat (2) @(negedge clk);
    chk_state("R3 mid chunk", 4, 1'b0, 1'b0);
    push(16'h2006, 1'b0, 0, 1'b0);
    @(negedge clk);
    push(16'h2007, 1'b0, 0, 1'b0);
    chk_state("R2 R3 gapped chunk", 8, 1'b0, 1'b0);
    for (int a = 0; a < 8; a++) read_chk(a, 16'h2000 + a, "R2 R10 readback");
  endtask

  task automatic t_full;
    for (int c = 8; c < DEPTH; c += CHUNK) push_chunk(16'h2000 + c);
    chk_state("R4 R6 full at 28", 28, 1'b1, 1'b1);
    push_chunk(16'hDE00);
    chk_state("R6 dump chunk", 28, 1'b1, 1'b1);
    for (int a = 0; a < DEPTH; a++) read_chk(a, 16'h2000 + a, "R6 ring untouched");
  endtask

  task automatic t_tail_same_cycle;
    for (int i = 0; i < CHUNK - 1; i++) push(16'hDE10, 1'b0, 0, 1'b0);
    push(16'hDE13, 1'b1, 8, 1'b0);
    chk_state("R9 tail write same cycle", 28, 1'b1, 1'b1);
    push_chunk(16'hDE20);
    chk_state("R7 R5 wrap after dump", 0, 1'b0, 1'b1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk_state("R8 clear", 0, 1'b0, 1'b0);
  endtask

  task automatic t_behind_tail;
    push_chunk(16'h3000);
    chk_state("R4 head below tail", 4, 1'b0, 1'b0);
    read_chk(0, 16'h3000, "R5 wrapped chunk data");
    read_chk(3, 16'h3003, "R5 wrapped chunk data");
    push_chunk(16'h3004);
    chk_state("R4 zero space below tail", 4, 1'b1, 1'b1);
    for (int i = 0; i < CHUNK - 1; i++) push(16'hDE30, 1'b0, 0, 1'b0);
    push(16'hDE33, 1'b0, 0, 1'b1);
    chk_state("R8 set beats clear", 4, 1'b1, 1'b1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk_state("R8 clear alone", 4, 1'b1, 1'b0);
  endtask

  task automatic t_equal_and_no_gap;
    tail_we = 1'b1; tail_wdata = AW'(4);
    @(negedge clk);
    tail_we = 1'b0;
    push_chunk(16'hDE40);
    for (int i = 0; i < CHUNK; i++) push(16'h4008 + i, 1'b0, 0, 1'b0);
    chk_state("R4 R5 equal pointers", 12, 1'b0, 1'b0);
    read_chk(4, 16'h3004, "R7 released chunk visible");
    for (int a = 8; a < 12; a++) read_chk(a, 16'h4000 + a, "R5 back-to-back chunk");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_full();
    t_tail_same_cycle();
    t_behind_tail();
    t_equal_and_no_gap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule